// File: doc/BRIEF.md
# Command Word Stream Parser

This block sits at the head of an accelerator's control path. It takes 32-bit command words one at a time over a valid/ready input and sorts each word into one of four kinds. A word can set a configuration register, start an operation, make the parser wait on earlier jobs, or stop the parser. Register-set commands come in two sizes. A single-word command takes its value from the header. A two-word command takes a full 32-bit value from the word that follows the header.

Two kinds of operation start are counted: kernel jobs and DMA jobs. The execution units report each finished job with a one-cycle pulse. A wait command holds the input stream until the matching count is at or below the requested level. Downstream units read the configuration through a combinational read port, which is indexed by opcode space and entry.

A stop command parks the parser in a halted state until a restart. A header with a reserved payload mode also halts the parser, and it raises an error flag that only reset clears.

Top module: `cmd_stream_parser`

## Requirements
- R1: A header word holds the 16-bit code in bits [15:0] and a 16-bit parameter in bits [31:16]. Code bits [15:14] give the payload mode: 00 means no payload and 01 means one payload word follows. Code bits [9:0] give the index, and code bits [13:10] are not decoded.
- R2: In mode 00, an index from 0x100 to 0x100+NREGS-1 is a register-set command. It writes entry (index-0x100) of space 0 with value {16'h0, parameter} and auxiliary field 0. The new value can be read on the port in the cycle after the header is accepted.
- R3: In mode 01, the parser takes exactly two words, and a word in the payload slot is never decoded as a command. When the payload word is accepted, entry `index` of space 1 gets data = payload and auxiliary field = the header parameter. Nothing is written when only the header has been accepted.
- R4: In mode 00, any index below 0x100 other than 0x000, 0x010, 0x011 and 0x012 is a kernel operation. It adds one to the kernel job count. `op_start` is high for exactly one cycle, in the cycle after acceptance, with `op_code` equal to the index and `op_param` equal to the parameter.
- R5: Index 0x010 is the DMA start. It pulses `op_start` in the same way as R4, with the parameter (channel*16+mode) passed through unchanged, and it adds one to the DMA job count instead of the kernel job count.
- R6: Each `kern_done` or `dma_done` pulse takes one from its count. A count that is already zero stays at zero.
- R7: Index 0x011 is the DMA wait, with level = parameter[3:0]. While the DMA count is above the level, `in_ready` stays low. Words are accepted again within two cycles after the count reaches the level.
- R8: Index 0x012 is the kernel wait, with level = parameter[1:0]. It behaves like R7 but is checked against the kernel job count.
- R9: Index 0x000 stops the parser whatever its parameter. After it, `halted` is high and `in_ready` is low. A `restart` pulse clears `halted` and parsing resumes.
- R10: A header in mode 10 or 11 sets `error` and `halted`. `restart` clears `halted` but leaves `error` set. Only reset clears `error`.
- R11: A word held on the input during a wait or a halt writes no register until that word is accepted.
- R12: After reset, `in_ready` is high, `halted`, `error` and `op_start` are low, and every register entry reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | Leave the halted state |
| in_valid | input | 1 | Command word valid |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Parser takes the word this cycle |
| kern_done | input | 1 | One kernel job finished |
| dma_done | input | 1 | One DMA job finished |
| op_start | output | 1 | Operation start pulse |
| op_code | output | 10 | Index of the started operation |
| op_param | output | 16 | Parameter of the started operation |
| rd_space | input | 1 | Read space: 0 single-word, 1 payload |
| rd_idx | input | 10 | Read entry index |
| rd_data | output | 32 | Value of the read entry |
| rd_aux | output | 16 | Auxiliary field of the read entry |
| halted | output | 1 | Parser stopped |
| error | output | 1 | Sticky reserved-mode error |

## Verification
Each wrong internal state shows up at a specific port. A wrong job count shows up as a wait that never releases or one that releases too early, and `in_ready` shows it within a few cycles of the deciding completion pulse. A payload slot that is lost or added leaves the parser out of step with the stream. The next header is then taken as data, or a payload is taken as a command, so either a stray or missing `op_start` or a wrong register value appears on the next access. A stall that leaks a write shows on the read port while the word is still being held.

// File: rtl/cmdp_pkg.sv
// Shared types and opcode constants for the command word stream parser.
// Assumes a 10-bit index field and a 2-bit payload mode field.
package cmdp_pkg;
    typedef enum logic [2:0] {
        C_REG, C_OPK, C_OPD, C_WAITD, C_WAITK, C_STOP, C_PAY, C_BAD
    } cmd_class_t;

    typedef enum logic [1:0] {S_HDR, S_PAY, S_WAIT, S_HALT} pstate_t;

    localparam logic [9:0] OP_STOP      = 10'h000;
    localparam logic [9:0] OP_DMA_START = 10'h010;
    localparam logic [9:0] OP_DMA_WAIT  = 10'h011;
    localparam logic [9:0] OP_KERN_WAIT = 10'h012;
    localparam logic [9:0] REG0_BASE    = 10'h100;

    localparam logic [1:0] MODE_NONE  = 2'b00;
    localparam logic [1:0] MODE_PAY32 = 2'b01;
endpackage

// File: rtl/cmdp_decoder.sv
// Sorts a header word into a command class from its payload mode and index.
// Purely combinational; assumes the caller only looks at it for header words.
module cmdp_decoder
    import cmdp_pkg::*;
(
    input  logic [1:0] mode,
    input  logic [9:0] idx,
    output cmd_class_t cls
);
    // Class selection: payload mode first, then index ranges and fixed ops.
    always_comb begin
        if (mode == MODE_PAY32) begin
            cls = C_PAY;
        end else if (mode != MODE_NONE) begin
            cls = C_BAD;
        end else if (idx >= REG0_BASE) begin
            cls = C_REG;
        end else begin
            case (idx)
                OP_STOP:      cls = C_STOP;
                OP_DMA_START: cls = C_OPD;
                OP_DMA_WAIT:  cls = C_WAITD;
                OP_KERN_WAIT: cls = C_WAITK;
                default:      cls = C_OPK;
            endcase
        end
    end
endmodule

// File: rtl/cmdp_job_counter.sv
// Outstanding-job counter: increments on a start, decrements on a completion.
// Saturates at zero and at all-ones; simultaneous inc and dec leave it unchanged.
module cmdp_job_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAXV = '1;

    // Count update with saturation at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && !dec && count != MAXV) begin
            count <= count + 1'b1;
        end else if (dec && !inc && count != '0) begin
            count <= count - 1'b1;
        end
    end

    // R6: a completion at zero keeps the count at zero.
    p_sat_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && dec && !inc) |=> (count == '0));

    // R6: a completion with a nonzero count lowers it by exactly one.
    p_dec_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (count != '0 && dec && !inc) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/cmdp_regfile.sv
// One opcode space of configuration storage: 32-bit value plus 16-bit aux field.
// Single write port, combinational read port; cleared by reset.
module cmdp_regfile #(
    parameter int NREGS = 16,
    parameter int IW    = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [31:0]   wr_data,
    input  logic [15:0]   wr_aux,
    input  logic [IW-1:0] rd_idx,
    output logic [31:0]   rd_data,
    output logic [15:0]   rd_aux
);
    logic [31:0] data_q [NREGS];
    logic [15:0] aux_q  [NREGS];

    // Entry storage: cleared on reset, written when wr_en is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                data_q[i] <= '0;
                aux_q[i]  <= '0;
            end
        end else if (wr_en) begin
            data_q[wr_idx] <= wr_data;
            aux_q[wr_idx]  <= wr_aux;
        end
    end

    // Read mux.
    assign rd_data = data_q[rd_idx];
    assign rd_aux  = aux_q[rd_idx];
endmodule

// File: rtl/cmd_stream_parser.sv
// Command word stream parser. Accepts 32-bit words over valid/ready, writes
// two register spaces, pulses operation starts, tracks outstanding kernel and
// DMA jobs, and stalls on wait commands. Assumes done pulses are one cycle each.
module cmd_stream_parser
    import cmdp_pkg::*;
#(
    parameter int NREGS = 16,
    parameter int CNTW  = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        restart,
    input  logic        in_valid,
    input  logic [31:0] in_data,
    output logic        in_ready,
    input  logic        kern_done,
    input  logic        dma_done,
    output logic        op_start,
    output logic [9:0]  op_code,
    output logic [15:0] op_param,
    input  logic        rd_space,
    input  logic [9:0]  rd_idx,
    output logic [31:0] rd_data,
    output logic [15:0] rd_aux,
    output logic        halted,
    output logic        error
);
    localparam int         IW   = $clog2(NREGS);
    localparam logic [9:0] NLIM = 10'(NREGS);

    pstate_t     state;
    cmd_class_t  cls;
    logic [9:0]  pay_idx;
    logic [15:0] pay_param;
    logic        dma_wait_q;
    logic [3:0]  lvl_q;
    logic [CNTW-1:0] kcnt, dcnt;

    logic [15:0] h_param;
    logic [1:0]  h_mode;
    logic [9:0]  h_idx;
    logic        unused_code_bits;

    assign h_param          = in_data[31:16];
    assign h_mode           = in_data[15:14];
    assign h_idx            = in_data[9:0];
    assign unused_code_bits = ^in_data[13:10];

    cmdp_decoder u_dec (.mode(h_mode), .idx(h_idx), .cls(cls));

    logic acc, hdr_acc, pay_acc, wait_ok;
    assign in_ready = (state == S_HDR) || (state == S_PAY);
    assign halted   = (state == S_HALT);
    assign acc      = in_valid && in_ready;
    assign hdr_acc  = acc && (state == S_HDR);
    assign pay_acc  = acc && (state == S_PAY);
    assign wait_ok  = dma_wait_q ? (dcnt <= CNTW'(lvl_q)) : (kcnt <= CNTW'(lvl_q));

    cmdp_job_counter #(.W(CNTW)) u_kcnt (
        .clk(clk), .rst_n(rst_n), .inc(hdr_acc && cls == C_OPK),
        .dec(kern_done), .count(kcnt));
    cmdp_job_counter #(.W(CNTW)) u_dcnt (
        .clk(clk), .rst_n(rst_n), .inc(hdr_acc && cls == C_OPD),
        .dec(dma_done), .count(dcnt));

    // Register write routing for the two opcode spaces.
    logic [9:0]    r0_off;
    logic [1:0]    wen;
    logic [IW-1:0] widx [2];
    logic [31:0]   wdat [2];
    logic [15:0]   waux [2];
    logic [31:0]   rdd  [2];
    logic [15:0]   rda  [2];

    assign r0_off  = h_idx - REG0_BASE;
    assign wen[0]  = hdr_acc && (cls == C_REG) && (r0_off < NLIM);
    assign wen[1]  = pay_acc && (pay_idx < NLIM);
    assign widx[0] = r0_off[IW-1:0];
    assign wdat[0] = {16'h0000, h_param};
    assign waux[0] = '0;
    assign widx[1] = pay_idx[IW-1:0];
    assign wdat[1] = in_data;
    assign waux[1] = pay_param;

    for (genvar sp = 0; sp < 2; sp++) begin : g_space
        cmdp_regfile #(.NREGS(NREGS), .IW(IW)) u_rf (
            .clk(clk), .rst_n(rst_n), .wr_en(wen[sp]), .wr_idx(widx[sp]),
            .wr_data(wdat[sp]), .wr_aux(waux[sp]), .rd_idx(rd_idx[IW-1:0]),
            .rd_data(rdd[sp]), .rd_aux(rda[sp]));
    end

    // Read port: out-of-range entries read as zero.
    assign rd_data = (rd_idx < NLIM) ? rdd[rd_space] : '0;
    assign rd_aux  = (rd_idx < NLIM) ? rda[rd_space] : '0;

    // Parser sequencing: header, payload slot, wait stall, halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_HDR;
            error      <= 1'b0;
            pay_idx    <= '0;
            pay_param  <= '0;
            dma_wait_q <= 1'b0;
            lvl_q      <= '0;
        end else begin
            case (state)
                S_HDR: if (hdr_acc) begin
                    case (cls)
                        C_PAY: begin
                            state     <= S_PAY;
                            pay_idx   <= h_idx;
                            pay_param <= h_param;
                        end
                        C_WAITD: begin
                            state      <= S_WAIT;
                            dma_wait_q <= 1'b1;
                            lvl_q      <= h_param[3:0];
                        end
                        C_WAITK: begin
                            state      <= S_WAIT;
                            dma_wait_q <= 1'b0;
                            lvl_q      <= {2'b00, h_param[1:0]};
                        end
                        C_STOP: state <= S_HALT;
                        C_BAD: begin
                            state <= S_HALT;
                            error <= 1'b1;
                        end
                        default: ;
                    endcase
                end
                S_PAY:  if (pay_acc) state <= S_HDR;
                S_WAIT: if (wait_ok) state <= S_HDR;
                S_HALT: if (restart) state <= S_HDR;
                default: state <= S_HDR;
            endcase
        end
    end

    // Operation start pulse, registered one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_start <= 1'b0;
            op_code  <= '0;
            op_param <= '0;
        end else begin
            op_start <= hdr_acc && (cls == C_OPK || cls == C_OPD);
            if (hdr_acc && (cls == C_OPK || cls == C_OPD)) begin
                op_code  <= h_idx;
                op_param <= h_param;
            end
        end
    end

    // R11: no register write while stalled on a wait.
    p_stall_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT) |-> (wen == 2'b00));

    // R3: the payload space is written only from the payload slot.
    p_pay_slot_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_PAY) |-> !wen[1]);

    // R7: a satisfied wait reopens the input on the next cycle.
    p_wait_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && wait_ok) |=> in_ready);

    // R9: halted persists until restart.
    p_halt_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !restart) |=> halted);

    // R10: a reserved mode halts with error, and error never clears itself.
    p_bad_halts_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_acc && h_mode[1]) |=> (halted && error));
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> error);
endmodule

// File: tb/cmd_stream_parser_test.sv
module cmd_stream_parser_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, restart, in_valid, kern_done, dma_done, rd_space;
    logic [31:0] in_data;
    logic [9:0]  rd_idx;
    logic        in_ready, op_start, halted, error;
    logic [9:0]  op_code;
    logic [15:0] op_param, rd_aux;
    logic [31:0] rd_data;

    int  nchk = 0;
    int  nbad = 0;
    bit  finished = 0;
    logic [25:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_stream_parser uut (
        .clk(clk), .rst_n(rst_n), .restart(restart), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .kern_done(kern_done),
        .dma_done(dma_done), .op_start(op_start), .op_code(op_code),
        .op_param(op_param), .rd_space(rd_space), .rd_idx(rd_idx),
        .rd_data(rd_data), .rd_aux(rd_aux), .halted(halted), .error(error));

    function automatic logic [31:0] hdr(input logic [1:0] m, input logic [9:0] i,
                                        input logic [15:0] p);
        return {p, m, 4'b0000, i};
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Monitor: every op_start pulse must match the head of the expected queue.
    always @(negedge clk) begin
        if (rst_n && op_start) begin
            if (exp_q.size() == 0) begin
                check(0, "R4 unexpected op_start", {6'b0, op_code, op_param}, 32'h0);
            end else begin
                logic [25:0] e;
                e = exp_q.pop_front();
                check({op_code, op_param} == e, "R4/R5 op_start code/param",
                      {6'b0, op_code, op_param}, {6'b0, e});
            end
        end
    end

    // Driver: present a word and return at the negedge after its acceptance.
    task automatic send(input logic [31:0] w);
        in_data  = w;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic rd(input logic sp, input logic [9:0] idx,
                      output logic [31:0] d, output logic [15:0] a);
        rd_space = sp;
        rd_idx   = idx;
        #1;
        d = rd_data;
        a = rd_aux;
    endtask

    task automatic pulse_done(input bit dma);
        if (dma) dma_done = 1'b1; else kern_done = 1'b1;
        @(negedge clk);
        dma_done  = 1'b0;
        kern_done = 1'b0;
    endtask

    task automatic pulse_restart();
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
    endtask

    task automatic wait_ready(input int maxc, output bit ok);
        ok = 1'b0;
        for (int i = 0; i <= maxc; i++) begin
            if (in_ready) begin
                ok = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        nchk++;
        nbad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [31:0] d;
        logic [15:0] a;
        bit ok;
        rst_n = 0; restart = 0; in_valid = 0; in_data = '0;
        kern_done = 0; dma_done = 0; rd_space = 0; rd_idx = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R12: reset state
        check(in_ready == 1'b1, "R12 in_ready", 32'(in_ready), 32'h1);
        check(!halted && !error, "R12 halted/error", {halted, error}, 32'h0);
        check(op_start == 1'b0, "R12 op_start", 32'(op_start), 32'h0);
        rd(1'b0, 10'd3, d, a);
        check(d == 32'h0, "R12 reg entry zero", d, 32'h0);

        // R2: single-word register set (R1 field layout via hdr)
        send(hdr(2'b00, 10'h103, 16'hBEEF));
        rd(1'b0, 10'd3, d, a);
        check(d == 32'h0000BEEF && a == 16'h0, "R2 space0 entry3", d, 32'h0000BEEF);
        send(hdr(2'b00, 10'h100, 16'h0001));
        rd(1'b0, 10'd0, d, a);
        check(d == 32'h1, "R2 space0 entry0", d, 32'h1);

        // R3: two-word command, header alone writes nothing
        send(hdr(2'b01, 10'd5, 16'h0007));
        rd(1'b1, 10'd5, d, a);
        check(d == 32'h0, "R3 no write after header only", d, 32'h0);
        send(32'hCAFEF00D);
        rd(1'b1, 10'd5, d, a);
        check(d == 32'hCAFEF00D, "R3 payload data", d, 32'hCAFEF00D);
        check(a == 16'h0007, "R3 payload aux", 32'(a), 32'h7);
        // payload that looks like an op header must not start anything
        send(hdr(2'b01, 10'd6, 16'h0002));
        send(hdr(2'b00, 10'h001, 16'h0001));
        rd(1'b1, 10'd6, d, a);
        check(d == 32'h00010001 && a == 16'h2, "R3 op-like payload stored", d, 32'h00010001);

        // R4: kernel operations
        exp_q.push_back({10'h001, 16'h1234});
        send(hdr(2'b00, 10'h001, 16'h1234));
        exp_q.push_back({10'h0FF, 16'h0000});
        send(hdr(2'b00, 10'h0FF, 16'h0000));
        @(negedge clk);
        check(exp_q.size() == 0, "R4 op pulses seen", exp_q.size(), 32'h0);

        // R8: kernel wait level 1 (param 5 -> bits[1:0]=1), kernel count 2
        send(hdr(2'b00, 10'h012, 16'h0005));
        repeat (3) @(negedge clk);
        check(in_ready == 1'b0, "R8 kernel wait stalls", 32'(in_ready), 32'h0);
        pulse_done(1'b0);
        wait_ready(3, ok);
        check(ok, "R8 kernel wait releases", 32'(in_ready), 32'h1);
        pulse_done(1'b0);

        // R5: DMA starts with channel*16+mode parameter
        exp_q.push_back({10'h010, 16'h0023});
        send(hdr(2'b00, 10'h010, 16'h0023));
        exp_q.push_back({10'h010, 16'h0010});
        send(hdr(2'b00, 10'h010, 16'h0010));
        @(negedge clk);
        check(exp_q.size() == 0, "R5 dma start pulses", exp_q.size(), 32'h0);

        // R7: DMA wait, param 0x21 -> level 1, DMA count 2; R11 hold during stall
        send(hdr(2'b00, 10'h011, 16'h0021));
        check(in_ready == 1'b0, "R7 dma wait stalls", 32'(in_ready), 32'h0);
        in_data  = hdr(2'b00, 10'h104, 16'h5555);
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        check(in_ready == 1'b0, "R7 still stalled", 32'(in_ready), 32'h0);
        rd(1'b0, 10'd4, d, a);
        check(d == 32'h0, "R11 no write during wait", d, 32'h0);
        pulse_done(1'b1);
        wait_ready(3, ok);
        check(ok, "R7 dma wait releases", 32'(in_ready), 32'h1);
        @(negedge clk);
        in_valid = 1'b0;
        rd(1'b0, 10'd4, d, a);
        check(d == 32'h5555, "R11 held word written after release", d, 32'h5555);
        pulse_done(1'b1);
        // already-satisfied DMA wait resumes promptly
        send(hdr(2'b00, 10'h011, 16'h0000));
        wait_ready(2, ok);
        check(ok, "R7 satisfied wait releases", 32'(in_ready), 32'h1);

        // R6: completions at zero must not wrap the kernel count
        pulse_done(1'b0);
        pulse_done(1'b0);
        exp_q.push_back({10'h002, 16'h0042});
        send(hdr(2'b00, 10'h002, 16'h0042));
        send(hdr(2'b00, 10'h012, 16'h0000));
        repeat (2) @(negedge clk);
        check(in_ready == 1'b0, "R6 wait 0 stalls with one job", 32'(in_ready), 32'h0);
        pulse_done(1'b0);
        wait_ready(3, ok);
        check(ok, "R6 count saturated at zero", 32'(in_ready), 32'h1);

        // R9: stop and restart
        send(hdr(2'b00, 10'h000, 16'hFFFF));
        check(halted == 1'b1 && in_ready == 1'b0, "R9 halted after stop",
              {halted, in_ready}, 32'h2);
        in_data  = hdr(2'b00, 10'h105, 16'h7777);
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        rd(1'b0, 10'd5, d, a);
        check(d == 32'h0, "R11 no write while halted", d, 32'h0);
        pulse_restart();
        check(halted == 1'b0, "R9 restart clears halted", 32'(halted), 32'h0);
        wait_ready(2, ok);
        @(negedge clk);
        in_valid = 1'b0;
        rd(1'b0, 10'd5, d, a);
        check(d == 32'h7777, "R9 parsing resumes", d, 32'h7777);

        // R10: reserved modes
        send(hdr(2'b10, 10'h105, 16'h0001));
        check(error && halted, "R10 mode 10 error+halt", {error, halted}, 32'h3);
        pulse_restart();
        check(!halted && error, "R10 restart keeps error", {error, halted}, 32'h2);
        send(hdr(2'b11, 10'h106, 16'h0001));
        check(halted == 1'b1, "R10 mode 11 halts", 32'(halted), 32'h1);
        pulse_restart();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(error == 1'b0, "R10 reset clears error", 32'(error), 32'h0);
        rd(1'b0, 10'd3, d, a);
        check(d == 32'h0, "R12 reset clears entries", d, 32'h0);

        check(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 32'h0);
        finish_up();
    end
endmodule